// File: doc/BRIEF.md
# Low-Power Mode Controller

This controller decides which power-down mode a processor core enters when it issues a sleep request, and when it leaves that mode again. At the moment of the request it picks a target from three settings: the standby-select bit, the clock-stop enable bit and a 64-bit module-stop mask. The target is ordinary sleep, all-module clock-stop or software standby. The controller then waits for the current bus cycle to finish before it enters the target. A watchdog that is running in watchdog mode vetoes software standby. A vetoed request leaves the core running and sets a sticky error flag.

While the core is stopped, qualified wake sources bring the controller back to the running state. The qualifiers are a global interrupt disable, a mask on every source except NMI, and routing of a source to the DMA engine. The way back passes through a one-cycle exception state, and the return to running raises a one-cycle exception-entry strobe. Driving the hardware-standby pin low overrides everything and parks the controller until the next reset. The outputs are the current mode and the stop controls for each clock domain: CPU, general modules, bus controller and I/O ports, the four 8-bit timer units, the watchdog and the oscillator. A further output places the bus in high impedance.

Every pin is a plain control or status signal. No port carries streamed data, so the block has no valid/ready handshake.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset (`rst_n` low, asynchronous) the mode is RUN (code 0), every stop output and `bus_hiz` are 0, and `exc_entry` and `stby_err` are 0.
- R2: In RUN, a sleep request that is not refused fixes a target mode at once. If `bus_done` is high in the same cycle, the target is entered on the next cycle. Otherwise the mode is WAIT (code 1) until the cycle after `bus_done` is high.
- R3: The target is CLKSTOP (code 3) when `cfg_stby_sel`=0, `cfg_cstop_en`=1 and every mask bit other than bits 59..56 is 1. Bits 59..56 may hold any value. With `cfg_stby_sel`=0 and any other setting, the target is SLEEP (code 2).
- R4: In SLEEP only `cpu_clk_stop` is 1.
- R5: In CLKSTOP, `cpu_clk_stop`, `mod_clk_stop` and `busio_stop` are 1, while `wdt_clk_stop`, `osc_stop` and `bus_hiz` are 0. `tmr_clk_stop` follows mask bits 59..56, with bit 56 driving unit 0.
- R6: With `cfg_stby_sel`=1 and `wdog_mode`=0, the target is SWSTBY (code 4). In SWSTBY every stop output is 1, `tmr_clk_stop` is 4'b1111, and `bus_hiz` is the inverse of `cfg_out_hold` as sampled at the request. Later changes to `cfg_out_hold` have no effect.
- R7: A request with `cfg_stby_sel`=1 and `wdog_mode`=1 is refused. The mode stays RUN and `stby_err` becomes 1. `stby_err` stays set until `err_clr` clears it, and a refusal in the same cycle as `err_clr` wins.
- R8: In SLEEP or CLKSTOP, a qualified wake from NMI, `irq[11:0]`, `tmr_irq` or `wdt_irq` moves the mode to EXC (code 5) on the next cycle. In SWSTBY only NMI and `irq` wake the controller.
- R9: `int_disable`=1 blocks every wake source. `int_mask_nonnmi`=1 blocks every source except NMI. `dma_route[i]`=1 blocks source i, where i=0..11 is `irq[i]`, i=12 is `tmr_irq` and i=13 is `wdt_irq`. NMI cannot be routed to the DMA engine.
- R10: EXC lasts exactly one cycle and is followed by RUN. `exc_entry` is 1 in that first RUN cycle only.
- R11: With `hwstby_n` low at a clock edge, the mode becomes HWSTBY (code 6) from any state, overriding any other request. HWSTBY drives every stop output, `osc_stop` and `bus_hiz` to 1, and only reset leaves it.
- R12: Sleep requests outside RUN have no effect. Wake sources in RUN and WAIT have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | Sleep request from the core |
| bus_done | input | 1 | Current bus cycle has finished |
| cfg_stby_sel | input | 1 | 1 selects software standby |
| cfg_cstop_en | input | 1 | Enables all-module clock-stop |
| cfg_out_hold | input | 1 | 1 keeps bus outputs driven in standby |
| mod_stop_mask | input | 64 | Module-stop mask |
| wdog_mode | input | 1 | Watchdog is running in watchdog mode |
| nmi | input | 1 | Non-maskable interrupt |
| irq | input | 12 | External interrupt lines |
| tmr_irq | input | 1 | 8-bit timer interrupt |
| wdt_irq | input | 1 | Watchdog interrupt |
| int_disable | input | 1 | Global interrupt disable |
| int_mask_nonnmi | input | 1 | Mask on all sources except NMI |
| dma_route | input | 14 | Source designated as DMA activation source |
| hwstby_n | input | 1 | Hardware standby pin, active low |
| err_clr | input | 1 | Clears the refused-standby flag |
| mode | output | 3 | Current mode code |
| cpu_clk_stop | output | 1 | Stop CPU clock |
| mod_clk_stop | output | 1 | Stop general module clocks |
| busio_stop | output | 1 | Stop bus controller and I/O ports |
| tmr_clk_stop | output | 4 | Stop each 8-bit timer unit |
| wdt_clk_stop | output | 1 | Stop watchdog clock |
| osc_stop | output | 1 | Stop oscillator |
| bus_hiz | output | 1 | Put address bus and bus control outputs in high impedance |
| exc_entry | output | 1 | One-cycle exception-entry strobe |
| stby_err | output | 1 | Sticky refused-standby flag |

## Verification
Two events can fall in the same cycle: the hardware-standby override and a regular transition, such as a qualified wake in SLEEP, a sleep request in RUN or `bus_done` in WAIT. The bench drives `hwstby_n` low in the very cycle that carries the other event. It then expects HWSTBY rather than EXC or the sleep target on the next cycle, and expects the controller to stay there when the wake persists. The same approach covers a refusal and `err_clr` arriving together, where the flag must remain set.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    MODE_RUN    = 3'd0,
    MODE_WAIT   = 3'd1,
    MODE_SLEEP  = 3'd2,
    MODE_CSTOP  = 3'd3,
    MODE_SSTBY  = 3'd4,
    MODE_EXC    = 3'd5,
    MODE_HSTBY  = 3'd6
  } lpm_mode_e;

  typedef struct packed {
    logic cpu;
    logic mods;
    logic busio;
    logic wdt;
    logic osc;
    logic hiz;
  } lpm_ctl_s;
endpackage

// File: rtl/lpm_elig.sv
module lpm_elig #(
  parameter int MASK_W = 64,
  parameter int TMR_LO = 56,
  parameter int TMR_W  = 4
) (
  input  logic              en,
  input  logic [MASK_W-1:0] mask,
  output logic              eligible
);
  localparam int TMR_HI = TMR_LO + TMR_W;

  logic [MASK_W-1:0] care_ok;

  // timer stop bits are don't-care; every other bit must be set
  for (genvar i = 0; i < MASK_W; i++) begin : g_bit
    if (i >= TMR_LO && i < TMR_HI) begin : g_dc
      assign care_ok[i] = 1'b1;
    end else begin : g_care
      assign care_ok[i] = mask[i];
    end
  end

  assign eligible = en & (&care_ok);
endmodule

// File: rtl/lpm_wake.sv
module lpm_wake #(
  parameter int NUM_IRQ = 12
) (
  input  logic               nmi,
  input  logic [NUM_IRQ-1:0] irq,
  input  logic               tmr_irq,
  input  logic               wdt_irq,
  input  logic               int_disable,
  input  logic               int_mask_nonnmi,
  input  logic [NUM_IRQ+1:0] dma_route,
  output logic               wake_ext,
  output logic               wake_all
);
  localparam int NSRC = NUM_IRQ + 2;

  logic [NSRC-1:0] src;
  logic [NSRC-1:0] src_ok;
  logic            nmi_ok;

  assign src = {wdt_irq, tmr_irq, irq};

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign src_ok[i] = src[i] & ~dma_route[i] & ~int_mask_nonnmi & ~int_disable;
  end

  assign nmi_ok   = nmi & ~int_disable;
  assign wake_ext = nmi_ok | (|src_ok[NUM_IRQ-1:0]);
  assign wake_all = wake_ext | src_ok[NUM_IRQ] | src_ok[NUM_IRQ+1];

  always_comb begin
    if (int_disable === 1'b1) begin
      assert_glob_block_R9: assert (wake_all == 1'b0);
    end
  end
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sleep_req,
  input  logic      bus_done,
  input  logic      cfg_stby_sel,
  input  logic      cfg_out_hold,
  input  logic      wdog_mode,
  input  logic      eligible,
  input  logic      wake_ext,
  input  logic      wake_all,
  input  logic      hwstby_n,
  input  logic      err_clr,
  output lpm_mode_e state,
  output logic      hold_q,
  output logic      exc_q,
  output logic      err_q
);
  lpm_mode_e state_q, nxt, tgt_q, tgt_now;
  logic      set_err, cap;

  always_comb begin
    nxt     = state_q;
    set_err = 1'b0;
    cap     = 1'b0;
    tgt_now = cfg_stby_sel ? MODE_SSTBY : (eligible ? MODE_CSTOP : MODE_SLEEP);
    unique case (state_q)
      MODE_RUN: begin
        if (sleep_req) begin
          if (cfg_stby_sel && wdog_mode) begin
            set_err = 1'b1;
          end else begin
            cap = 1'b1;
            nxt = bus_done ? tgt_now : MODE_WAIT;
          end
        end
      end
      MODE_WAIT:  if (bus_done) nxt = tgt_q;
      MODE_SLEEP: if (wake_all) nxt = MODE_EXC;
      MODE_CSTOP: if (wake_all) nxt = MODE_EXC;
      MODE_SSTBY: if (wake_ext) nxt = MODE_EXC;
      MODE_EXC:   nxt = MODE_RUN;
      MODE_HSTBY: nxt = MODE_HSTBY;
      default:    nxt = MODE_RUN;
    endcase
    if (!hwstby_n) begin
      nxt     = MODE_HSTBY;
      set_err = 1'b0;
      cap     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MODE_RUN;
      tgt_q   <= MODE_SLEEP;
      hold_q  <= 1'b0;
      exc_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= nxt;
      exc_q   <= (state_q == MODE_EXC) && (nxt == MODE_RUN);
      if (cap) begin
        tgt_q  <= tgt_now;
        hold_q <= cfg_out_hold;
      end
      if (set_err)      err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  assign state = state_q;

  assert_hstby_entry_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !hwstby_n |=> state_q == MODE_HSTBY);

  assert_hstby_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == MODE_HSTBY |=> state_q == MODE_HSTBY);

  assert_exc_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_q |-> (state_q == MODE_RUN) && ($past(state_q) == MODE_EXC));

  assert_refuse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hwstby_n && state_q == MODE_RUN && sleep_req && cfg_stby_sel && wdog_mode)
      |=> (state_q == MODE_RUN) && err_q);

  assert_wait_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hwstby_n && state_q == MODE_WAIT && !bus_done) |=> state_q == MODE_WAIT);
endmodule

// File: rtl/lpm_outdec.sv
module lpm_outdec
  import lpm_pkg::*;
#(
  parameter int TMR_W = 4
) (
  input  lpm_mode_e        state,
  input  logic             hold_q,
  input  logic [TMR_W-1:0] tmr_mask,
  output lpm_ctl_s         ctl,
  output logic [TMR_W-1:0] tmr_stop
);
  always_comb begin
    ctl      = '0;
    tmr_stop = '0;
    unique case (state)
      MODE_SLEEP: ctl.cpu = 1'b1;
      MODE_CSTOP: begin
        ctl.cpu   = 1'b1;
        ctl.mods  = 1'b1;
        ctl.busio = 1'b1;
        tmr_stop  = tmr_mask;
      end
      MODE_SSTBY: begin
        ctl      = '1;
        ctl.hiz  = ~hold_q;
        tmr_stop = '1;
      end
      MODE_HSTBY: begin
        ctl      = '1;
        tmr_stop = '1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int NUM_IRQ = 12,
  parameter int MASK_W  = 64,
  parameter int TMR_LO  = 56,
  parameter int TMR_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sleep_req,
  input  logic               bus_done,
  input  logic               cfg_stby_sel,
  input  logic               cfg_cstop_en,
  input  logic               cfg_out_hold,
  input  logic [MASK_W-1:0]  mod_stop_mask,
  input  logic               wdog_mode,
  input  logic               nmi,
  input  logic [NUM_IRQ-1:0] irq,
  input  logic               tmr_irq,
  input  logic               wdt_irq,
  input  logic               int_disable,
  input  logic               int_mask_nonnmi,
  input  logic [NUM_IRQ+1:0] dma_route,
  input  logic               hwstby_n,
  input  logic               err_clr,
  output logic [2:0]         mode,
  output logic               cpu_clk_stop,
  output logic               mod_clk_stop,
  output logic               busio_stop,
  output logic [TMR_W-1:0]   tmr_clk_stop,
  output logic               wdt_clk_stop,
  output logic               osc_stop,
  output logic               bus_hiz,
  output logic               exc_entry,
  output logic               stby_err
);
  logic      eligible, wake_ext, wake_all, hold_q;
  lpm_mode_e state;
  lpm_ctl_s  ctl;

  lpm_elig #(.MASK_W(MASK_W), .TMR_LO(TMR_LO), .TMR_W(TMR_W)) u_elig (
    .en(cfg_cstop_en), .mask(mod_stop_mask), .eligible(eligible)
  );

  lpm_wake #(.NUM_IRQ(NUM_IRQ)) u_wake (
    .nmi(nmi), .irq(irq), .tmr_irq(tmr_irq), .wdt_irq(wdt_irq),
    .int_disable(int_disable), .int_mask_nonnmi(int_mask_nonnmi),
    .dma_route(dma_route), .wake_ext(wake_ext), .wake_all(wake_all)
  );

  lpm_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .bus_done(bus_done),
    .cfg_stby_sel(cfg_stby_sel), .cfg_out_hold(cfg_out_hold),
    .wdog_mode(wdog_mode), .eligible(eligible), .wake_ext(wake_ext),
    .wake_all(wake_all), .hwstby_n(hwstby_n), .err_clr(err_clr),
    .state(state), .hold_q(hold_q), .exc_q(exc_entry), .err_q(stby_err)
  );

  lpm_outdec #(.TMR_W(TMR_W)) u_dec (
    .state(state), .hold_q(hold_q),
    .tmr_mask(mod_stop_mask[TMR_LO +: TMR_W]),
    .ctl(ctl), .tmr_stop(tmr_clk_stop)
  );

  assign mode         = 3'(state);
  assign cpu_clk_stop = ctl.cpu;
  assign mod_clk_stop = ctl.mods;
  assign busio_stop   = ctl.busio;
  assign wdt_clk_stop = ctl.wdt;
  assign osc_stop     = ctl.osc;
  assign bus_hiz      = ctl.hiz;

  assert_wake_only_stopped_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (hwstby_n && (state == MODE_RUN || state == MODE_WAIT)) |=> state != MODE_EXC);
endmodule

// File: tb/lpm_ctrl_tb.sv
module lpm_ctrl_tb;
  localparam int M_RUN = 0, M_WAIT = 1, M_SLEEP = 2, M_CSTOP = 3,
                 M_SSTBY = 4, M_EXC = 5, M_HSTBY = 6;

  logic        clk = 0, rst_n = 0;
  logic        sleep_req = 0, bus_done = 0, cfg_stby_sel = 0, cfg_cstop_en = 0, cfg_out_hold = 0;
  logic [63:0] mod_stop_mask = '0;
  logic        wdog_mode = 0, nmi = 0, tmr_irq = 0, wdt_irq = 0;
  logic [11:0] irq = '0;
  logic        int_disable = 0, int_mask_nonnmi = 0, hwstby_n = 1, err_clr = 0;
  logic [13:0] dma_route = '0;
  logic [2:0]  mode;
  logic        cpu_clk_stop, mod_clk_stop, busio_stop, wdt_clk_stop, osc_stop, bus_hiz;
  logic        exc_entry, stby_err;
  logic [3:0]  tmr_clk_stop;

  int n_tests = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  lpm_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .bus_done(bus_done),
    .cfg_stby_sel(cfg_stby_sel), .cfg_cstop_en(cfg_cstop_en), .cfg_out_hold(cfg_out_hold),
    .mod_stop_mask(mod_stop_mask), .wdog_mode(wdog_mode), .nmi(nmi), .irq(irq),
    .tmr_irq(tmr_irq), .wdt_irq(wdt_irq), .int_disable(int_disable),
    .int_mask_nonnmi(int_mask_nonnmi), .dma_route(dma_route), .hwstby_n(hwstby_n),
    .err_clr(err_clr), .mode(mode), .cpu_clk_stop(cpu_clk_stop), .mod_clk_stop(mod_clk_stop),
    .busio_stop(busio_stop), .tmr_clk_stop(tmr_clk_stop), .wdt_clk_stop(wdt_clk_stop),
    .osc_stop(osc_stop), .bus_hiz(bus_hiz), .exc_entry(exc_entry), .stby_err(stby_err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run hung, act=%0d exp=<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input string rq, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", rq, act, exp);
    end
  endtask

  task automatic clr_wake();
    nmi = 0; irq = '0; tmr_irq = 0; wdt_irq = 0;
    int_disable = 0; int_mask_nonnmi = 0; dma_route = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; sleep_req = 0; bus_done = 0; hwstby_n = 1; err_clr = 0;
    wdog_mode = 0; clr_wake();
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic enter(input logic stby, input logic en, input logic [63:0] mask, input logic hold);
    cfg_stby_sel = stby; cfg_cstop_en = en; mod_stop_mask = mask; cfg_out_hold = hold;
    sleep_req = 1; bus_done = 1;
    @(negedge clk);
    sleep_req = 0; bus_done = 0;
  endtask

  initial begin
    do_reset();
    // R1 reset state
    check("R1 mode", mode, M_RUN);
    check("R1 stops", {cpu_clk_stop, mod_clk_stop, busio_stop, wdt_clk_stop, osc_stop, bus_hiz}, 0);
    check("R1 tmr", tmr_clk_stop, 0);
    check("R1 exc/err", {exc_entry, stby_err}, 0);

    // R3/R4/R5 eligibility sweep: timer bits and single cleared bits
    for (int en = 0; en < 2; en++) begin
      for (int k = 0; k < 16 + 64; k++) begin
        logic [63:0] m;
        int exp_m;
        if (k < 16) m = {4'hF, 4'(k), 56'hFF_FFFF_FFFF_FFFF};
        else begin
          if (k - 16 >= 56 && k - 16 < 60) continue;
          m = ~(64'd1 << (k - 16));
          m[59:56] = 4'(k);
        end
        do_reset();
        enter(0, en[0], m, 0);
        exp_m = (en == 1 && ((m | (64'hF << 56)) == '1)) ? M_CSTOP : M_SLEEP;
        check("R3 target", mode, exp_m);
        check("R4/R5 cpu", cpu_clk_stop, 1);
        check("R4/R5 mod/busio", {mod_clk_stop, busio_stop}, exp_m == M_CSTOP ? 3 : 0);
        check("R5 tmr", tmr_clk_stop, exp_m == M_CSTOP ? int'(m[59:56]) : 0);
        check("R4/R5 wdt/osc/hiz", {wdt_clk_stop, osc_stop, bus_hiz}, 0);
      end
    end

    // R2 wait for bus cycle; R12 wake in WAIT ignored
    do_reset();
    cfg_stby_sel = 0; cfg_cstop_en = 0; sleep_req = 1; bus_done = 0;
    @(negedge clk);
    sleep_req = 0; nmi = 1;
    check("R2 wait", mode, M_WAIT);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R2/R12 still wait", mode, M_WAIT);
    end
    nmi = 0; bus_done = 1;
    @(negedge clk);
    bus_done = 0;
    check("R2 entered after bus_done", mode, M_SLEEP);
    // R12 sleep request in SLEEP ignored
    cfg_stby_sel = 1; sleep_req = 1; bus_done = 1;
    @(negedge clk);
    sleep_req = 0; bus_done = 0;
    check("R12 sleep_req ignored", mode, M_SLEEP);

    // R12 wake in RUN ignored
    do_reset();
    nmi = 1; irq = '1;
    @(negedge clk);
    @(negedge clk);
    check("R12 wake in RUN mode", mode, M_RUN);
    check("R12 wake in RUN exc", exc_entry, 0);
    clr_wake();

    // R6 software standby and latched hold
    for (int h = 0; h < 2; h++) begin
      do_reset();
      enter(1, 0, '0, h[0]);
      check("R6 mode", mode, M_SSTBY);
      check("R6 stops", {cpu_clk_stop, mod_clk_stop, busio_stop, wdt_clk_stop, osc_stop}, 31);
      check("R6 tmr", tmr_clk_stop, 15);
      check("R6 hiz", bus_hiz, 1 - h);
      cfg_out_hold = ~h[0];
      @(negedge clk);
      check("R6 hiz latched", bus_hiz, 1 - h);
    end

    // R7 refusal and sticky flag
    do_reset();
    wdog_mode = 1;
    enter(1, 0, '0, 0);
    check("R7 refused mode", mode, M_RUN);
    check("R7 err set", stby_err, 1);
    @(negedge clk);
    check("R7 err sticky", stby_err, 1);
    err_clr = 1;
    @(negedge clk);
    err_clr = 0;
    check("R7 err cleared", stby_err, 0);
    err_clr = 1;
    enter(1, 0, '0, 0);
    err_clr = 0;
    check("R7 set wins over clear", stby_err, 1);

    // R8/R9/R10 wake sweep
    for (int md = 0; md < 3; md++) begin
      for (int s = 0; s < 15; s++) begin
        for (int c = 0; c < 8; c++) begin
          int tm;
          bit woke;
          tm = (md == 0) ? M_SLEEP : (md == 1) ? M_CSTOP : M_SSTBY;
          do_reset();
          enter(md == 2, md == 1, '1, 0);
          int_disable = c[0]; int_mask_nonnmi = c[1];
          dma_route = c[2] ? ((s == 0) ? 14'h3FFF : (14'd1 << (s - 1))) : 14'd0;
          if (s == 0) nmi = 1;
          else if (s <= 12) irq[s-1] = 1;
          else if (s == 13) tmr_irq = 1;
          else wdt_irq = 1;
          woke = !c[0] && !(s != 0 && (c[1] || c[2])) && !(md == 2 && s > 12);
          @(negedge clk);
          clr_wake();
          check("R8/R9 wake", mode, woke ? M_EXC : tm);
          if (woke) begin
            @(negedge clk);
            check("R10 run after exc", mode, M_RUN);
            check("R10 exc strobe", exc_entry, 1);
            @(negedge clk);
            check("R10 exc one cycle", exc_entry, 0);
          end
        end
      end
    end

    // R11 hardware standby collides with wake, sleep entry and bus_done
    do_reset();
    enter(0, 0, '0, 0);
    nmi = 1; hwstby_n = 0;
    @(negedge clk);
    hwstby_n = 1;
    check("R11 hstby over wake", mode, M_HSTBY);
    check("R11 outputs", {cpu_clk_stop, mod_clk_stop, busio_stop, wdt_clk_stop, osc_stop, bus_hiz}, 63);
    check("R11 tmr", tmr_clk_stop, 15);
    @(negedge clk);
    check("R11 stays", mode, M_HSTBY);
    check("R11 no exc", exc_entry, 0);
    clr_wake();

    do_reset();
    cfg_stby_sel = 0; sleep_req = 1; bus_done = 1; hwstby_n = 0;
    @(negedge clk);
    sleep_req = 0; bus_done = 0; hwstby_n = 1;
    check("R11 hstby over sleep", mode, M_HSTBY);

    do_reset();
    sleep_req = 1;
    @(negedge clk);
    sleep_req = 0; bus_done = 1; hwstby_n = 0;
    @(negedge clk);
    bus_done = 0; hwstby_n = 1;
    check("R11 hstby over bus_done", mode, M_HSTBY);

    do_reset();
    wdog_mode = 1; cfg_stby_sel = 1; sleep_req = 1; hwstby_n = 0;
    @(negedge clk);
    sleep_req = 0; hwstby_n = 1;
    check("R11 hstby suppresses refusal flag", stby_err, 0);
    do_reset();
    check("R11 reset leaves hstby", mode, M_RUN);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule